// File: doc/BRIEF.md
# MDIO Management Frame Master

This block issues single management transactions to an external PHY over a two-wire serial pair. The wires are a management clock and a bidirectional data line, with the data line split into output, output enable and input. A one-cycle start strobe launches the frame. The strobe captures four inputs:

- a read/write select;
- a 5-bit PHY address;
- a 5-bit register address;
- 16 bits of write data.

The frame is a long run of ones, then a start pattern, an opcode, both addresses, a turnaround and a 16-bit data field.

Each serial bit takes three equal phases: clock low, clock high, clock low. The output data is held through all three phases. The phase length is a parameter measured in system clock cycles. On a read, the block gives up the data line from the turnaround onward. It samples the PHY's data at the end of each high phase and presents the 16-bit result on the read data output. A one-cycle done pulse ends every frame. A start that arrives while a frame is under way is dropped.

The controller is a state machine with these states:

- IDLE: waiting for start.
- PRE: preamble ones.
- SOF: start pattern.
- OP: opcode.
- PHY: PHY address.
- REG: register address.
- TA: turnaround.
- WDAT: write data.
- RDAT: read data.
- DONE: done pulse.

Its transitions are:

- IDLE goes to PRE on start.
- Each field state goes to the next when its final bit ends. The order is PRE, SOF, OP, PHY, REG, TA.
- TA goes to RDAT for a read and to WDAT for a write.
- RDAT and WDAT go to DONE.
- DONE returns to IDLE after one cycle.

Top module: `mdio_frame_master`

## Requirements
- R1: After reset and while idle, the management clock is low, the output enable is low and done is low.
- R2: Every frame opens with 34 bits of 1 driven on the data output with output enable high.
- R3: After the preamble the block drives the start pattern 0 then 1. It then drives the opcode: 1 then 0 for a read (select = 1), or 0 then 1 for a write (select = 0).
- R4: The 5-bit PHY address follows, then the 5-bit register address, each sent most significant bit first.
- R5: In a write frame the turnaround is driven as 1 then 0. The 16 write data bits follow, most significant bit first, with output enable high throughout.
- R6: In a read frame the output enable is low from the single turnaround bit to the end of the frame. The 16 bits that follow the turnaround are sampled on the data input at the end of each clock-high phase, most significant bit first. They appear on the read data output when done pulses.
- R7: Each bit lasts 3 x PHASE_CYCLES system cycles: low, then high for PHASE_CYCLES cycles, then low. The data output and output enable do not change while the clock is high or across the trailing low phase.
- R8: Done is high for exactly one cycle after the trailing low phase of the last bit. By then a write frame has carried 66 clock pulses and a read frame 65.
- R9: A start strobe is ignored while a frame is in progress, including the done cycle. The frame in flight keeps its captured fields, and no extra frame follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a frame |
| rd_nwr | input | 1 | 1 selects a read frame, 0 a write frame |
| phy_addr | input | AW | PHY address, captured at start |
| reg_addr | input | AW | Register address, captured at start |
| wr_data | input | DW | Write data, captured at start |
| mdi | input | 1 | Serial data from the PHY |
| mdc | output | 1 | Management clock |
| mdo | output | 1 | Serial data to the PHY |
| mdo_oe | output | 1 | Output enable for the serial data line |
| rd_data | output | DW | Data collected by the last read frame |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
A wrong state or a miscounted field shows up as a wrong data value or enable level on the very next clock pulse. The scoreboard compares every pulse against the frame built from the requirements, so such a fault is caught at the first misplaced bit, not at the end of the frame. A broken phase counter shows up at the next clock rise or fall as a wrong period or high time. A shifted read sample point shows up only at the done pulse, as a read word rotated or filled with wrong bits. A start that leaks through while busy shows up as captured fields changing mid-frame or as extra clock pulses after done.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRE,
        ST_SOF,
        ST_OP,
        ST_PHY,
        ST_REG,
        ST_TA,
        ST_WDAT,
        ST_RDAT,
        ST_DONE
    } mdio_state_e;

    localparam logic [1:0] PH_LEAD  = 2'd0;
    localparam logic [1:0] PH_HIGH  = 2'd1;
    localparam logic [1:0] PH_TRAIL = 2'd2;

endpackage

// File: rtl/mdio_phase_timer.sv
module mdio_phase_timer #(
    parameter int PHASE_CYCLES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    output logic [1:0] phase,
    output logic       phase_end,
    output logic       bit_end
);
    import mdio_pkg::*;

    localparam int CW = (PHASE_CYCLES > 1) ? $clog2(PHASE_CYCLES) : 1;
    localparam logic [CW-1:0] DIV_LAST = CW'(PHASE_CYCLES - 1);

    logic [CW-1:0] div_q;
    logic [1:0]    phase_q;

    assign phase     = phase_q;
    assign phase_end = run && (div_q == DIV_LAST);
    assign bit_end   = phase_end && (phase_q == PH_TRAIL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q   <= '0;
            phase_q <= PH_LEAD;
        end else if (!run) begin
            div_q   <= '0;
            phase_q <= PH_LEAD;
        end else if (phase_end) begin
            div_q   <= '0;
            phase_q <= (phase_q == PH_TRAIL) ? PH_LEAD : phase_q + 2'd1;
        end else begin
            div_q   <= div_q + 1'b1;
        end
    end

endmodule

// File: rtl/mdio_rx_shift.sv
module mdio_rx_shift #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shift_en,
    input  logic          din,
    output logic [DW-1:0] dout
);
    logic [DW-1:0] sr_q;

    assign dout = sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (shift_en) begin
            sr_q <= {sr_q[DW-2:0], din};
        end
    end

endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master #(
    parameter int PHASE_CYCLES = 2,
    parameter int PRE_BITS     = 34,
    parameter int AW           = 5,
    parameter int DW           = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          rd_nwr,
    input  logic [AW-1:0] phy_addr,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          mdi,
    output logic          mdc,
    output logic          mdo,
    output logic          mdo_oe,
    output logic [DW-1:0] rd_data,
    output logic          done
);
    import mdio_pkg::*;

    localparam int MAXF = (PRE_BITS > DW) ? PRE_BITS : DW;
    localparam int CNTW = $clog2(MAXF + 1);

    mdio_state_e   state_q, state_d;
    logic [CNTW-1:0] cnt_q;
    logic [CNTW-1:0] field_last;
    logic          rd_q;
    logic [AW-1:0] phy_q, reg_q;
    logic [DW-1:0] wdat_q;

    logic          run;
    logic [1:0]    phase;
    logic          phase_end, bit_end;
    logic          field_end;
    logic          rx_shift;

    logic [AW-1:0] phy_sh, reg_sh;
    logic [DW-1:0] wdat_sh;

    assign run = (state_q != ST_IDLE) && (state_q != ST_DONE);

    mdio_phase_timer #(.PHASE_CYCLES(PHASE_CYCLES)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .phase     (phase),
        .phase_end (phase_end),
        .bit_end   (bit_end)
    );

    assign rx_shift = (state_q == ST_RDAT) && phase_end && (phase == PH_HIGH);

    mdio_rx_shift #(.DW(DW)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (rx_shift),
        .din      (mdi),
        .dout     (rd_data)
    );

    // Last bit index of the field belonging to each state
    always_comb begin
        unique case (state_q)
            ST_PRE:  field_last = CNTW'(PRE_BITS - 1);
            ST_SOF:  field_last = CNTW'(1);
            ST_OP:   field_last = CNTW'(1);
            ST_PHY:  field_last = CNTW'(AW - 1);
            ST_REG:  field_last = CNTW'(AW - 1);
            ST_TA:   field_last = rd_q ? CNTW'(0) : CNTW'(1);
            ST_WDAT: field_last = CNTW'(DW - 1);
            ST_RDAT: field_last = CNTW'(DW - 1);
            default: field_last = '0;
        endcase
    end

    assign field_end = bit_end && (cnt_q == field_last);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)     state_d = ST_PRE;
            ST_PRE:  if (field_end) state_d = ST_SOF;
            ST_SOF:  if (field_end) state_d = ST_OP;
            ST_OP:   if (field_end) state_d = ST_PHY;
            ST_PHY:  if (field_end) state_d = ST_REG;
            ST_REG:  if (field_end) state_d = ST_TA;
            ST_TA:   if (field_end) state_d = rd_q ? ST_RDAT : ST_WDAT;
            ST_WDAT: if (field_end) state_d = ST_DONE;
            ST_RDAT: if (field_end) state_d = ST_DONE;
            ST_DONE:                state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // State register, bit counter and captured request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            rd_q    <= 1'b0;
            phy_q   <= '0;
            reg_q   <= '0;
            wdat_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE) begin
                cnt_q <= '0;
                if (start) begin
                    rd_q   <= rd_nwr;
                    phy_q  <= phy_addr;
                    reg_q  <= reg_addr;
                    wdat_q <= wr_data;
                end
            end else if (field_end) begin
                cnt_q <= '0;
            end else if (bit_end) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign phy_sh  = phy_q << cnt_q;
    assign reg_sh  = reg_q << cnt_q;
    assign wdat_sh = wdat_q << cnt_q;

    // Output decode
    always_comb begin
        mdo    = 1'b0;
        mdo_oe = 1'b0;
        unique case (state_q)
            ST_PRE: begin
                mdo    = 1'b1;
                mdo_oe = 1'b1;
            end
            ST_SOF: begin
                mdo    = (cnt_q != '0);
                mdo_oe = 1'b1;
            end
            ST_OP: begin
                mdo    = rd_q ? (cnt_q == '0) : (cnt_q != '0);
                mdo_oe = 1'b1;
            end
            ST_PHY: begin
                mdo    = phy_sh[AW-1];
                mdo_oe = 1'b1;
            end
            ST_REG: begin
                mdo    = reg_sh[AW-1];
                mdo_oe = 1'b1;
            end
            ST_TA: begin
                mdo    = !rd_q && (cnt_q == '0);
                mdo_oe = !rd_q;
            end
            ST_WDAT: begin
                mdo    = wdat_sh[DW-1];
                mdo_oe = 1'b1;
            end
            default: begin
                mdo    = 1'b0;
                mdo_oe = 1'b0;
            end
        endcase
    end

    assign mdc  = run && (phase == PH_HIGH);
    assign done = (state_q == ST_DONE);

endmodule

// File: rtl/mdio_frame_master_chk.sv
module mdio_frame_master_chk #(
    parameter int AW = 5,
    parameter int DW = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  mdc,
    input logic                  mdo,
    input logic                  mdo_oe,
    input logic                  done,
    input mdio_pkg::mdio_state_e state_q,
    input logic [AW-1:0]         phy_q,
    input logic [AW-1:0]         reg_q,
    input logic [DW-1:0]         wdat_q
);
    import mdio_pkg::*;

    // R7
    mdo_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdo) |-> (!mdc && !$past(mdc)));

    // R7
    oe_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdo_oe) |-> (!mdc && !$past(mdc)));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!mdc && !mdo_oe));

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> ($stable(phy_q) && $stable(reg_q) && $stable(wdat_q)));

endmodule

bind mdio_frame_master mdio_frame_master_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mdc     (mdc),
    .mdo     (mdo),
    .mdo_oe  (mdo_oe),
    .done    (done),
    .state_q (state_q),
    .phy_q   (phy_q),
    .reg_q   (reg_q),
    .wdat_q  (wdat_q)
);

// File: tb/mdio_frame_master_test.sv
module mdio_frame_master_test;
    localparam int PC  = 2;
    localparam int AW  = 5;
    localparam int DW  = 16;
    localparam int HDR = 34 + 2 + 2 + AW + AW;

    typedef struct {
        logic val;
        logic oe;
        logic care;
        int   req;
    } exp_bit_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          rd_nwr = 1'b0;
    logic [AW-1:0] phy_addr = '0;
    logic [AW-1:0] reg_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          mdi = 1'b0;
    logic          mdc, mdo, mdo_oe, done;
    logic [DW-1:0] rd_data;

    int checks = 0;
    int errors = 0;

    exp_bit_t exp_q[$];
    int       bitnum = 0;
    logic     phy_rd = 1'b0;
    logic [DW-1:0] phy_word = '0;
    int       done_cnt = 0;
    logic     done_prev = 1'b0;
    logic     mdc_prev = 1'b0;
    logic     bit_val = 1'b0;
    int       cyc = 0;
    int       last_rise = -1;
    int       high_len = 0;

    always #5 clk = ~clk;

    mdio_frame_master #(.PHASE_CYCLES(PC), .PRE_BITS(34), .AW(AW), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_nwr(rd_nwr),
        .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
        .mdi(mdi), .mdc(mdc), .mdo(mdo), .mdo_oe(mdo_oe),
        .rd_data(rd_data), .done(done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic v, input logic oe, input logic care, input int req);
        exp_bit_t e;
        e.val = v; e.oe = oe; e.care = care; e.req = req;
        exp_q.push_back(e);
    endtask

    // Driver: builds the expected frame from the requirements
    task automatic push_frame(input logic rd, input logic [AW-1:0] pa,
                              input logic [AW-1:0] ra, input logic [DW-1:0] wd);
        for (int i = 0; i < 34; i++) push(1'b1, 1'b1, 1'b1, 2);        // R2
        push(1'b0, 1'b1, 1'b1, 3); push(1'b1, 1'b1, 1'b1, 3);          // R3 start
        push(rd, 1'b1, 1'b1, 3);   push(!rd, 1'b1, 1'b1, 3);           // R3 opcode
        for (int i = AW-1; i >= 0; i--) push(pa[i], 1'b1, 1'b1, 4);    // R4
        for (int i = AW-1; i >= 0; i--) push(ra[i], 1'b1, 1'b1, 4);    // R4
        if (rd) begin
            push(1'b0, 1'b0, 1'b0, 6);                                 // R6 turnaround
            for (int i = 0; i < DW; i++) push(1'b0, 1'b0, 1'b0, 6);
        end else begin
            push(1'b1, 1'b1, 1'b1, 5); push(1'b0, 1'b1, 1'b1, 5);      // R5
            for (int i = DW-1; i >= 0; i--) push(wd[i], 1'b1, 1'b1, 5);
        end
    endtask

    // Monitor and PHY model, sampled on the falling system clock
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (mdc && !mdc_prev) begin
                bit_val = mdo;
                high_len = 1;
                if (last_rise >= 0)
                    check(cyc - last_rise == 3*PC, "R7", "bit period", cyc - last_rise, 3*PC);
                last_rise = cyc;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8", "clock pulse beyond frame", bitnum, -1);
                end else begin
                    exp_bit_t e;
                    e = exp_q.pop_front();
                    check(mdo_oe == e.oe, $sformatf("R%0d", e.req), $sformatf("oe bit %0d", bitnum), mdo_oe, e.oe);
                    if (e.care)
                        check(mdo == e.val, $sformatf("R%0d", e.req), $sformatf("data bit %0d", bitnum), mdo, e.val);
                end
                if (phy_rd && bitnum >= HDR + 1 && bitnum < HDR + 1 + DW)
                    mdi = phy_word[DW-1-(bitnum-HDR-1)];
                bitnum++;
            end else if (mdc) begin
                high_len++;
            end else if (!mdc && mdc_prev) begin
                check(high_len == PC, "R7", "clock high length", high_len, PC);
                check(mdo == bit_val, "R7", "data held after fall", mdo, bit_val);
            end
            if (done) begin
                check(!done_prev, "R8", "done width", done_prev, 0);
                check(exp_q.size() == 0, "R8", "pulses left at done", exp_q.size(), 0);
                if (phy_rd) check(rd_data == phy_word, "R6", "read word", rd_data, phy_word);
                done_cnt++;
                last_rise = -1;
            end
        end
        mdc_prev  = mdc;
        done_prev = done;
    end

    task automatic run_frame(input logic rd, input logic [AW-1:0] pa,
                             input logic [AW-1:0] ra, input logic [DW-1:0] wd,
                             input logic [DW-1:0] pw, input bit stray);
        int d0;
        @(negedge clk);
        phy_rd = rd; phy_word = pw; bitnum = 0;
        push_frame(rd, pa, ra, wd);
        rd_nwr = rd; phy_addr = pa; reg_addr = ra; wr_data = wd; start = 1'b1;
        d0 = done_cnt;
        @(negedge clk);
        start = 1'b0;
        if (stray) begin
            // R9: a second request in mid-frame with other fields
            repeat (100) @(negedge clk);
            rd_nwr = !rd; phy_addr = ~pa; reg_addr = ~ra; wr_data = ~wd; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        for (int i = 0; i < 2000 && done_cnt == d0; i++) @(negedge clk);
        check(done_cnt == d0 + 1, "R8", "done seen", done_cnt - d0, 1);
        check(bitnum == (rd ? HDR + 1 + DW : HDR + 2 + DW), "R8", "pulse count", bitnum, rd ? HDR + 1 + DW : HDR + 2 + DW);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R8 watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(mdc == 0 && mdo_oe == 0 && done == 0, "R1", "outputs in reset", {mdc, mdo_oe, done}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(mdc == 0 && mdo_oe == 0 && done == 0, "R1", "outputs idle", {mdc, mdo_oe, done}, 0);

        run_frame(1'b0, 5'h01, 5'h10, 16'hA5C3, 16'h0, 0);      // write
        run_frame(1'b1, 5'h1F, 5'h03, 16'h0, 16'hB901, 0);      // read
        run_frame(1'b0, 5'h00, 5'h1F, 16'hFFFF, 16'h0, 0);      // write corners
        run_frame(1'b1, 5'h15, 5'h0A, 16'h0, 16'h8001, 1);      // read with stray start
        run_frame(1'b0, 5'h0A, 5'h15, 16'h0001, 16'h0, 1);      // write with stray start

        // R9: start presented during the done cycle
        @(negedge clk);
        phy_rd = 1'b1; phy_word = 16'h4404; bitnum = 0;
        push_frame(1'b1, 5'h02, 5'h11, 16'h0);
        rd_nwr = 1'b1; phy_addr = 5'h02; reg_addr = 5'h11; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 2000 && !done; i++) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (30) @(negedge clk);
        check(bitnum == HDR + 1 + DW, "R9", "no frame after start at done", bitnum, HDR + 1 + DW);
        check(mdc == 0 && mdo_oe == 0, "R1", "idle after frame", {mdc, mdo_oe}, 0);
        check(rd_data == 16'h4404, "R6", "read word held", rd_data, 16'h4404);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule